// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block sits at the issue stage of a pipeline that issues in program order but lets results finish out of order. Several function units of different latencies share one register-file write port. Every cycle the decoder presents at most one instruction: a unit class, a destination register, and two source registers, each with a flag that says whether it is read. The block answers in the same cycle. It either dispatches the instruction or holds it. While the instruction is held, the decoder keeps it in place, so nothing younger can pass it.

Hazards are tracked with one pending-write bit per register. The bit is set when an instruction that writes the register is dispatched. It is cleared when the write-back report for that register arrives. Sources are not recorded, because the units capture their operands at dispatch, so a write-after-read hazard cannot occur. A short shift register of reserved write-back cycles stops two units from using the single write port in the same cycle. Each function unit drives its own busy bit directly into the block.

Top module: `sb_issue_scoreboard`

## Requirements
- R1: After reset no register has a write outstanding and no write-back cycle is reserved. A valid instruction whose unit is not busy is therefore dispatched in the same cycle it is presented.
- R2: Unit classes are encoded 0 integer, 1 add, 2 multiply, 3 divide. Busy bit n belongs to class n. An instruction is never dispatched while the busy bit of its own class is set, and busy bits of other classes have no effect on it.
- R3: An instruction is held while either source whose use flag is 1 names a register with a write outstanding (read-after-write).
- R4: A source whose use flag is 0 does not take part in the read-after-write check.
- R5: An instruction is held while its destination already has a write outstanding (write-after-write), so each register has at most one outstanding write.
- R6: A dispatch marks its destination as pending from the next cycle on. A write-back report clears the mark from the next cycle on. A write-back in the current cycle does not release a held instruction until the following cycle.
- R7: When a write-back report and a dispatch name the same register in the same cycle, the register stays pending.
- R8: The write-back delays are 1 cycle for integer, 1 for add, 3 for multiply and 4 for divide (all parameters). A dispatch reserves the write port that many cycles later. An instruction whose write-back would fall on a cycle that is already reserved is held.
- R9: `stall` is high exactly when an instruction is valid and not dispatched. With no valid instruction nothing is dispatched and no pending state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction presented this cycle |
| instr_unit | input | 2 | Unit class (0 int, 1 add, 2 mul, 3 div) |
| instr_dst | input | REGW | Destination register |
| instr_src1 | input | REGW | First source register |
| instr_src1_use | input | 1 | First source is read |
| instr_src2 | input | REGW | Second source register |
| instr_src2_use | input | 1 | Second source is read |
| unit_busy | input | 4 | Busy bit per unit class |
| wb_valid | input | 1 | Write-back occurring this cycle |
| wb_dst | input | REGW | Register being written back |
| disp_fire | output | 1 | Instruction dispatched this cycle |
| stall | output | 1 | Instruction held this cycle |

## Verification
A wrongly set pending bit shows up as a stall on the next instruction that reads or writes that register, even though no write is outstanding. A bit that is lost shows up as a premature dispatch. Either error appears at `disp_fire` in the very cycle such an instruction is presented. A corrupted reservation bit shows up within at most the longest unit latency, as a stall or dispatch on an instruction whose write-back would land on that cycle. The bench follows every cycle with a model built from register sets and a table of reserved write-back cycles, and it drives the write-back reports from that model.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        FU_INT = 2'd0,
        FU_ADD = 2'd1,
        FU_MUL = 2'd2,
        FU_DIV = 2'd3
    } fu_e;

    localparam int NFU = 4;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sb_pending.sv
module sb_pending #(
    parameter int NREG = 32,
    parameter int REGW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [REGW-1:0] set_idx,
    input  logic            clr_en,
    input  logic [REGW-1:0] clr_idx,
    output logic [NREG-1:0] pend_q
);

    typedef struct packed {
        logic [NREG-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.pend[clr_idx] = 1'b0;
        end
        // dispatch wins over a same-cycle write-back to the same register
        if (set_en) begin
            st_d.pend[set_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;

endmodule

// File: rtl/sb_wb_slots.sv
module sb_wb_slots #(
    parameter int DEPTH = 4,
    parameter int LATW  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim_en,
    input  logic [LATW-1:0]  claim_lat,
    output logic [DEPTH-1:0] slot_q
);

    // bit j set: the write port is taken j+1 cycles from now
    typedef struct packed {
        logic [DEPTH-1:0] slot;
    } slot_st_t;

    slot_st_t st_d, st_q;

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        logic shifted;
        if (j + 1 < DEPTH) begin : g_mid
            assign shifted = st_q.slot[j+1];
        end else begin : g_top
            assign shifted = 1'b0;
        end
        always_comb begin
            st_d.slot[j] = shifted | (claim_en && (claim_lat == LATW'(j + 2)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_q = st_q.slot;

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard
    import sb_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int REGW    = $clog2(NREG),
    parameter int LAT_INT = 1,
    parameter int LAT_ADD = 1,
    parameter int LAT_MUL = 3,
    parameter int LAT_DIV = 4,
    parameter int DEPTH   = 4,
    parameter int LATW    = $clog2(DEPTH + 1)
) (
    input  logic             valid,
    input  fu_e              unit,
    input  logic [REGW-1:0]  dst,
    input  logic [REGW-1:0]  src1,
    input  logic             src1_use,
    input  logic [REGW-1:0]  src2,
    input  logic             src2_use,
    input  logic [NFU-1:0]   busy,
    input  logic [NREG-1:0]  pend,
    input  logic [DEPTH-1:0] slots,
    output logic             fire,
    output logic [LATW-1:0]  lat
);

    logic [1:0] uidx;
    logic       unit_busy;
    logic       raw_a, raw_b, waw, port_clash;

    always_comb begin
        unique case (unit)
            FU_INT:  lat = LATW'(LAT_INT);
            FU_ADD:  lat = LATW'(LAT_ADD);
            FU_MUL:  lat = LATW'(LAT_MUL);
            default: lat = LATW'(LAT_DIV);
        endcase
    end

    always_comb begin
        port_clash = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (lat == LATW'(j + 1)) begin
                port_clash = slots[j];
            end
        end
    end

    always_comb begin
        uidx      = unit;
        unit_busy = busy[uidx];
        raw_a     = src1_use && pend[src1];
        raw_b     = src2_use && pend[src2];
        waw       = pend[dst];
        fire      = valid && !unit_busy && !raw_a && !raw_b && !waw && !port_clash;
    end

endmodule

// File: rtl/sb_issue_scoreboard.sv
module sb_issue_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int LAT_INT = 1,
    parameter int LAT_ADD = 1,
    parameter int LAT_MUL = 3,
    parameter int LAT_DIV = 4,
    localparam int REGW   = $clog2(NREG),
    localparam int DEPTH  = max2(max2(LAT_INT, LAT_ADD), max2(LAT_MUL, LAT_DIV)),
    localparam int LATW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [1:0]      instr_unit,
    input  logic [REGW-1:0] instr_dst,
    input  logic [REGW-1:0] instr_src1,
    input  logic            instr_src1_use,
    input  logic [REGW-1:0] instr_src2,
    input  logic            instr_src2_use,
    input  logic [3:0]      unit_busy,
    input  logic            wb_valid,
    input  logic [REGW-1:0] wb_dst,
    output logic            disp_fire,
    output logic            stall
);

    logic [NREG-1:0]  pend_q;
    logic [DEPTH-1:0] slot_q;
    logic [LATW-1:0]  lat_sel;
    fu_e              unit_cls;

    assign unit_cls = fu_e'(instr_unit);

    sb_hazard #(
        .NREG    (NREG),
        .REGW    (REGW),
        .LAT_INT (LAT_INT),
        .LAT_ADD (LAT_ADD),
        .LAT_MUL (LAT_MUL),
        .LAT_DIV (LAT_DIV),
        .DEPTH   (DEPTH),
        .LATW    (LATW)
    ) u_hazard (
        .valid    (instr_valid),
        .unit     (unit_cls),
        .dst      (instr_dst),
        .src1     (instr_src1),
        .src1_use (instr_src1_use),
        .src2     (instr_src2),
        .src2_use (instr_src2_use),
        .busy     (unit_busy),
        .pend     (pend_q),
        .slots    (slot_q),
        .fire     (disp_fire),
        .lat      (lat_sel)
    );

    sb_pending #(
        .NREG (NREG),
        .REGW (REGW)
    ) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (disp_fire),
        .set_idx (instr_dst),
        .clr_en  (wb_valid),
        .clr_idx (wb_dst),
        .pend_q  (pend_q)
    );

    sb_wb_slots #(
        .DEPTH (DEPTH),
        .LATW  (LATW)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim_en  (disp_fire),
        .claim_lat (lat_sel),
        .slot_q    (slot_q)
    );

    assign stall = instr_valid && !disp_fire;

endmodule

// File: rtl/sb_issue_scoreboard_chk.sv
module sb_issue_scoreboard_chk #(
    parameter int NREG  = 32,
    parameter int REGW  = 5,
    parameter int DEPTH = 4,
    parameter int LATW  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [1:0]       instr_unit,
    input logic [REGW-1:0]  instr_dst,
    input logic [REGW-1:0]  instr_src1,
    input logic             instr_src1_use,
    input logic [REGW-1:0]  instr_src2,
    input logic             instr_src2_use,
    input logic [3:0]       unit_busy,
    input logic             wb_valid,
    input logic [REGW-1:0]  wb_dst,
    input logic             disp_fire,
    input logic [NREG-1:0]  pend_q,
    input logic [DEPTH-1:0] slot_q,
    input logic [LATW-1:0]  lat
);

    logic slot_taken;
    always_comb begin
        slot_taken = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (lat == LATW'(j + 1)) begin
                slot_taken = slot_q[j];
            end
        end
    end

    a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && unit_busy[instr_unit] |-> !disp_fire);

    a_r3_raw_src1: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr_src1_use && pend_q[instr_src1] |-> !disp_fire);

    a_r3_raw_src2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr_src2_use && pend_q[instr_src2] |-> !disp_fire);

    a_r5_waw: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[instr_dst] |-> !disp_fire);

    a_r6_set_on_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |=> pend_q[$past(instr_dst)]);

    a_r6_clear_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !(disp_fire && instr_dst == wb_dst) |=> !pend_q[$past(wb_dst)]);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && disp_fire && instr_dst == wb_dst |=> pend_q[$past(wb_dst)]);

    a_r8_port_free: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> !slot_taken);

    a_r9_idle_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !disp_fire);

endmodule

bind sb_issue_scoreboard sb_issue_scoreboard_chk #(
    .NREG  (NREG),
    .REGW  (REGW),
    .DEPTH (DEPTH),
    .LATW  (LATW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_valid    (instr_valid),
    .instr_unit     (instr_unit),
    .instr_dst      (instr_dst),
    .instr_src1     (instr_src1),
    .instr_src1_use (instr_src1_use),
    .instr_src2     (instr_src2),
    .instr_src2_use (instr_src2_use),
    .unit_busy      (unit_busy),
    .wb_valid       (wb_valid),
    .wb_dst         (wb_dst),
    .disp_fire      (disp_fire),
    .pend_q         (pend_q),
    .slot_q         (slot_q),
    .lat            (lat_sel)
);

// File: tb/test_sb_issue_scoreboard.sv
module test_sb_issue_scoreboard;

    localparam int NREG = 32;
    localparam int RW   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [1:0]    instr_unit = '0;
    logic [RW-1:0] instr_dst = '0, instr_src1 = '0, instr_src2 = '0;
    logic          instr_src1_use = 1'b0, instr_src2_use = 1'b0;
    logic [3:0]    unit_busy = '0;
    logic          wb_valid = 1'b0;
    logic [RW-1:0] wb_dst = '0;
    logic          disp_fire, stall;

    sb_issue_scoreboard i_sb_issue_scoreboard (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_unit(instr_unit),
        .instr_dst(instr_dst), .instr_src1(instr_src1), .instr_src1_use(instr_src1_use),
        .instr_src2(instr_src2), .instr_src2_use(instr_src2_use), .unit_busy(unit_busy),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .disp_fire(disp_fire), .stall(stall)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit pend_m [NREG];
    int occ [int];

    logic          cv = 1'b0;
    logic [1:0]    cu = '0;
    logic [RW-1:0] cd = '0, cs1 = '0, cs2 = '0;
    logic          cs1u = 1'b0, cs2u = 1'b0;
    logic [3:0]    cbusy = '0;
    logic          sp_en = 1'b0;
    logic [RW-1:0] sp_reg = '0;
    logic          dut_fire, model_fire;
    bit            done = 0;

    function automatic int lat_of(input logic [1:0] u);
        case (u)
            2'd0: return 1;
            2'd1: return 1;
            2'd2: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", tag, what, cyc, act, exp);
        end
    endtask

    task automatic tick();
        logic wv;
        logic [RW-1:0] wd;
        logic ef;
        string tag;
        bit r_busy, r_raw, r_waw, r_port;
        @(negedge clk);
        wv = 1'b0;
        wd = '0;
        if (occ.exists(cyc)) begin
            wv = 1'b1;
            wd = RW'(occ[cyc]);
        end
        if (sp_en) begin
            wv = 1'b1;
            wd = sp_reg;
        end
        instr_valid = cv; instr_unit = cu; instr_dst = cd;
        instr_src1 = cs1; instr_src1_use = cs1u;
        instr_src2 = cs2; instr_src2_use = cs2u;
        unit_busy = cbusy; wb_valid = wv; wb_dst = wd;
        #2;
        r_busy = cbusy[cu];
        r_raw  = (cs1u && pend_m[cs1]) || (cs2u && pend_m[cs2]);
        r_waw  = pend_m[cd];
        r_port = occ.exists(cyc + lat_of(cu));
        ef = cv && !r_busy && !r_raw && !r_waw && !r_port;
        if (!cv) tag = "R9";
        else if (r_busy) tag = "R2";
        else if (r_raw) tag = "R3";
        else if (r_waw) tag = "R5";
        else if (r_port) tag = "R8";
        else tag = "R1";
        check(tag, disp_fire, ef, "dispatch");
        check("R9", stall, cv && !ef, "stall");
        dut_fire = disp_fire;
        model_fire = ef;
        @(posedge clk);
        #1;
        if (wv) pend_m[wd] = 0;
        if (ef) begin
            pend_m[cd] = 1;
            occ[cyc + lat_of(cu)] = int'(cd);
        end
        if (occ.exists(cyc)) occ.delete(cyc);
        cyc++;
    endtask

    task automatic put(input logic [1:0] u, input int d, input int s1, input logic u1,
                       input int s2, input logic u2);
        cv = 1'b1; cu = u; cd = RW'(d);
        cs1 = RW'(s1); cs1u = u1; cs2 = RW'(s2); cs2u = u2;
    endtask

    task automatic idle(input int n);
        cv = 1'b0;
        repeat (n) tick();
    endtask

    task automatic issue_wait();
        for (int k = 0; k < 60; k++) begin
            tick();
            if (model_fire) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < NREG; i++) pend_m[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        #2;
        check("R1", disp_fire, 1'b0, "reset dispatch");
        check("R1", stall, 1'b0, "reset stall");
        rst_n = 1'b1;

        // R1: empty scoreboard dispatches at once
        put(2'd0, 1, 2, 1, 3, 1); tick(); check("R1", dut_fire, 1'b1, "first dispatch");
        // R3 and R6: r1 written back in this cycle, released the next
        put(2'd1, 4, 1, 1, 0, 0); tick(); check("R3", dut_fire, 1'b0, "raw hold");
        tick(); check("R6", dut_fire, 1'b1, "released after write-back");
        // R4: unused sources ignored
        put(2'd3, 7, 0, 0, 0, 0); tick(); check("R1", dut_fire, 1'b1, "div dispatch");
        put(2'd0, 8, 7, 0, 7, 0); tick(); check("R4", dut_fire, 1'b1, "unused source");
        // R5: second write to r7 waits for the divide
        put(2'd0, 7, 0, 0, 0, 0);
        tick(); check("R5", dut_fire, 1'b0, "waw hold 1");
        tick(); check("R5", dut_fire, 1'b0, "waw hold 2");
        tick(); check("R5", dut_fire, 1'b0, "waw hold 3");
        tick(); check("R5", dut_fire, 1'b1, "waw release");
        // R8: write port reservations
        idle(6);
        put(2'd3, 9, 0, 0, 0, 0); tick(); check("R8", dut_fire, 1'b1, "div issue");
        put(2'd2, 10, 0, 0, 0, 0); tick(); check("R8", dut_fire, 1'b0, "mul port clash");
        tick(); check("R8", dut_fire, 1'b1, "mul next slot");
        put(2'd0, 11, 0, 0, 0, 0); tick(); check("R8", dut_fire, 1'b0, "int clash div");
        tick(); check("R8", dut_fire, 1'b0, "int clash mul");
        tick(); check("R8", dut_fire, 1'b1, "int free slot");
        // R2: only own busy bit matters
        idle(4);
        cbusy = 4'b1110; put(2'd0, 12, 0, 0, 0, 0); tick(); check("R2", dut_fire, 1'b1, "other busy");
        cbusy = 4'b0001; put(2'd0, 13, 0, 0, 0, 0); tick(); check("R2", dut_fire, 1'b0, "own busy 1");
        tick(); check("R2", dut_fire, 1'b0, "own busy 2");
        cbusy = 4'b0000; tick(); check("R2", dut_fire, 1'b1, "busy released");
        cbusy = 4'b1000; put(2'd3, 14, 0, 0, 0, 0); tick(); check("R2", dut_fire, 1'b0, "div busy");
        cbusy = 4'b0000; tick(); check("R2", dut_fire, 1'b1, "div free");
        // R7: same-cycle set and clear
        idle(6);
        put(2'd2, 15, 0, 0, 0, 0); sp_en = 1'b1; sp_reg = 5'd15;
        tick(); check("R7", dut_fire, 1'b1, "mul with write-back");
        sp_en = 1'b0;
        put(2'd0, 16, 15, 1, 0, 0); tick(); check("R7", dut_fire, 1'b0, "still pending");
        issue_wait();
        // R9: invalid slot changes nothing
        cv = 1'b0; cu = 2'd0; cd = 5'd17; tick();
        check("R9", dut_fire, 1'b0, "idle fire");
        check("R9", stall, 1'b0, "idle stall");
        put(2'd0, 18, 17, 1, 17, 1); tick(); check("R9", dut_fire, 1'b1, "no state from idle");
        put(2'd1, 19, 18, 1, 0, 0); tick(); check("R6", dut_fire, 1'b0, "set visible");
        tick(); check("R6", dut_fire, 1'b1, "clear visible");

        // mixed stream compared with the model every cycle
        for (int n = 0; n < 1500; n++) begin
            if ($urandom % 6 == 0) begin
                cbusy = 4'b0000;
                idle(1 + $urandom % 3);
            end
            put(2'($urandom), int'($urandom % 8), int'($urandom % 8), 1'($urandom),
                int'($urandom % 8), 1'($urandom));
            for (int k = 0; k < 80; k++) begin
                for (int b = 0; b < 4; b++) cbusy[b] = ($urandom % 8 == 0);
                tick();
                if (model_fire) break;
            end
        end
        cbusy = 4'b0000;
        idle(6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule